// File: doc/BRIEF.md
# Strided Rectangle Stream Writer

This block takes one AXI4-Stream packet and lays it into memory as a rectangle of equal-length lines. A one-cycle start strobe captures the configuration: the base address of the rectangle, the number of bytes in each line, the distance in bytes between the starts of consecutive lines, the number of lines, and a 4-bit cache attribute and a 4-bit user attribute. The configuration inputs may change freely after the start strobe.

For every line the block first presents a write command on a valid/ready command port. The command carries the line start address, the line byte count and both attributes. It then passes the line's stream beats through, unchanged, to a write-data port. The first line begins at the base address. Each later line begins one stride after the start of the line before it, so the memory skipped between lines is the stride minus the line length. The whole rectangle arrives as a single packet, and the block checks that TLAST comes exactly on the final beat of the final line. A premature TLAST (underrun) or a missing one (overrun) raises a sticky error and parks the block until reset. Illegal configurations are refused at the start strobe, and no transfer begins.

Top module: `rect_writer`

## Requirements
- R1: A start strobe with a legal configuration produces a first write command whose address is the base address, whose byte count is the line length, and whose cache and user fields equal the configured 4-bit attributes (the usual cache value is 4'b0011).
- R2: Line k (counted from 0) is commanded at base + k*stride, and exactly the configured number of line commands is issued per transfer.
- R3: Stream data passes to wData unchanged. wValid follows sTvalid and sTready follows wReady while a line is transferring. wLast is high on the last beat of every line.
- R4: Each line carries line-length/4 beats of 32 bits. A command that is not accepted holds its values. No data beat moves while a command is pending, and the next line's command appears only after the previous line's last beat.
- R5: done pulses high for one cycle, in the cycle after the final beat of the final line is accepted together with TLAST.
- R6: A beat accepted with TLAST before the final beat of the final line sets errUnderrun. The flag stays set until reset, and the block then holds sTready and cmdValid low and ignores start.
- R7: The final beat of the final line accepted without TLAST sets errOverrun. It is sticky and halts the block in the same way as R6.
- R8: A start strobe is refused, with errCfg high for the following cycle and no command issued, when the line count is 0, the base address is not a multiple of 4, or the line length is 0 or not a multiple of 4.
- R9: sTready is low after reset and whenever no transfer is running.
- R10: The address, stride, line count and attributes used for a transfer are those present at the start strobe. Later changes on the configuration inputs do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture configuration and begin a transfer |
| cfgBase | input | 32 | Rectangle base byte address |
| cfgLineBytes | input | 16 | Bytes per line |
| cfgStride | input | 16 | Byte distance between line starts |
| cfgLines | input | 13 | Number of lines |
| cfgCache | input | 4 | Cache attribute for every command |
| cfgUser | input | 4 | User attribute for every command |
| cmdValid | output | 1 | Write command valid |
| cmdReady | input | 1 | Write command accepted |
| cmdAddr | output | 32 | Line start address |
| cmdBytes | output | 16 | Line byte count |
| cmdCache | output | 4 | Cache attribute |
| cmdUser | output | 4 | User attribute |
| sTdata | input | 32 | Stream data |
| sTvalid | input | 1 | Stream valid |
| sTlast | input | 1 | Stream end of packet |
| sTready | output | 1 | Stream ready |
| wData | output | 32 | Write data |
| wValid | output | 1 | Write data valid |
| wLast | output | 1 | Last beat of the current line |
| wReady | input | 1 | Write data accepted |
| done | output | 1 | Transfer finished pulse |
| errCfg | output | 1 | Configuration refused pulse |
| errUnderrun | output | 1 | Sticky early-TLAST error |
| errOverrun | output | 1 | Sticky missing-TLAST error |

## Verification
The main path is swept over line lengths of one, two and three beats, one to three lines, and three strides: equal to the line length, one word larger, and a wide fixed stride. This separates an address that merely advances by the line length from one that truly uses the stride, and single-beat lines from multi-beat lines for the wLast marking. Every other run stalls wReady on a line's first beat, which shows that sTready is coupled to the write side rather than tied high. TLAST is placed early, at a line end that is not the final one, and omitted on the final beat, to tell underrun apart from overrun. Each illegal configuration is applied on its own, so that every rejection condition is exercised separately.

// File: rtl/rect_pkg.sv
package rect_pkg;
  typedef struct packed {
    logic load;
    logic nextLine;
    logic beat;
  } rectStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_HALT
  } rectState_t;
endpackage

// File: rtl/rect_dp.sv
module rect_dp
  import rect_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 13,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rectStrobe_t       strb,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLineBytes,
  input  logic [LEN_W-1:0]  cfgStride,
  input  logic [CNT_W-1:0]  cfgLines,
  input  logic [ATTR_W-1:0] cfgCache,
  input  logic [ATTR_W-1:0] cfgUser,
  output logic              cfgOk,
  output logic [ADDR_W-1:0] lineAddr,
  output logic [LEN_W-1:0]  lineBytes,
  output logic [ATTR_W-1:0] cache,
  output logic [ATTR_W-1:0] user,
  output logic              lastBeat,
  output logic              lastLine
);
  localparam int BYTES_W = DATA_W / 8;
  localparam int ALIGN_W = $clog2(BYTES_W);

  logic [LEN_W-1:0] strideQ;
  logic [CNT_W-1:0] linesQ;
  logic [CNT_W-1:0] lineCnt;
  logic [LEN_W-1:0] beatCnt;
  logic [LEN_W-1:0] lineBeats;

  assign cfgOk = (cfgLines != '0) &&
                 (cfgBase[ALIGN_W-1:0] == '0) &&
                 (cfgLineBytes != '0) &&
                 (cfgLineBytes[ALIGN_W-1:0] == '0);

  assign lineBeats = lineBytes >> ALIGN_W;
  assign lastBeat  = (beatCnt == LEN_W'(lineBeats - 1'b1));
  assign lastLine  = (lineCnt == CNT_W'(linesQ - 1'b1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineAddr  <= '0;
      lineBytes <= '0;
      strideQ   <= '0;
      linesQ    <= '0;
      cache     <= '0;
      user      <= '0;
      lineCnt   <= '0;
      beatCnt   <= '0;
    end else if (strb.load) begin
      lineAddr  <= cfgBase;
      lineBytes <= cfgLineBytes;
      strideQ   <= cfgStride;
      linesQ    <= cfgLines;
      cache     <= cfgCache;
      user      <= cfgUser;
      lineCnt   <= '0;
      beatCnt   <= '0;
    end else begin
      if (strb.beat) begin
        beatCnt <= lastBeat ? '0 : beatCnt + 1'b1;
      end
      if (strb.nextLine) begin
        lineCnt  <= lineCnt + 1'b1;
        lineAddr <= lineAddr + ADDR_W'(strideQ);
      end
    end
  end
endmodule

// File: rtl/rect_ctrl.sv
module rect_ctrl
  import rect_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cfgOk,
  input  logic        cmdReady,
  input  logic        sTvalid,
  input  logic        sTlast,
  input  logic        wReady,
  input  logic        lastBeat,
  input  logic        lastLine,
  output rectStrobe_t strb,
  output logic        cmdValid,
  output logic        dataEn,
  output logic        done,
  output logic        errCfg,
  output logic        errUnderrun,
  output logic        errOverrun
);
  rectState_t state;
  logic beatFire;
  logic finalBeat;

  assign cmdValid  = (state == ST_CMD);
  assign dataEn    = (state == ST_DATA);
  assign beatFire  = dataEn && sTvalid && wReady;
  assign finalBeat = lastBeat && lastLine;

  always_comb begin
    strb          = '0;
    strb.load     = (state == ST_IDLE) && start && cfgOk;
    strb.beat     = beatFire;
    strb.nextLine = beatFire && lastBeat && !lastLine && !sTlast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      done        <= 1'b0;
      errCfg      <= 1'b0;
      errUnderrun <= 1'b0;
      errOverrun  <= 1'b0;
    end else begin
      done   <= 1'b0;
      errCfg <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (cfgOk) state <= ST_CMD;
            else       errCfg <= 1'b1;
          end
        end
        ST_CMD: begin
          if (cmdReady) state <= ST_DATA;
        end
        ST_DATA: begin
          if (beatFire) begin
            if (sTlast && !finalBeat) begin
              errUnderrun <= 1'b1;
              state       <= ST_HALT;
            end else if (finalBeat && !sTlast) begin
              errOverrun <= 1'b1;
              state      <= ST_HALT;
            end else if (finalBeat) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else if (lastBeat) begin
              state <= ST_CMD;
            end
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/rect_writer.sv
module rect_writer
  import rect_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 13,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLineBytes,
  input  logic [LEN_W-1:0]  cfgStride,
  input  logic [CNT_W-1:0]  cfgLines,
  input  logic [ATTR_W-1:0] cfgCache,
  input  logic [ATTR_W-1:0] cfgUser,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [LEN_W-1:0]  cmdBytes,
  output logic [ATTR_W-1:0] cmdCache,
  output logic [ATTR_W-1:0] cmdUser,
  input  logic [DATA_W-1:0] sTdata,
  input  logic              sTvalid,
  input  logic              sTlast,
  output logic              sTready,
  output logic [DATA_W-1:0] wData,
  output logic              wValid,
  output logic              wLast,
  input  logic              wReady,
  output logic              done,
  output logic              errCfg,
  output logic              errUnderrun,
  output logic              errOverrun
);
  rectStrobe_t strb;
  logic cfgOk;
  logic lastBeat;
  logic lastLine;
  logic dataEn;

  rect_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgOk(cfgOk),
    .cmdReady(cmdReady), .sTvalid(sTvalid), .sTlast(sTlast), .wReady(wReady),
    .lastBeat(lastBeat), .lastLine(lastLine), .strb(strb),
    .cmdValid(cmdValid), .dataEn(dataEn), .done(done), .errCfg(errCfg),
    .errUnderrun(errUnderrun), .errOverrun(errOverrun)
  );

  rect_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .CNT_W(CNT_W), .ATTR_W(ATTR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgBase(cfgBase), .cfgLineBytes(cfgLineBytes), .cfgStride(cfgStride),
    .cfgLines(cfgLines), .cfgCache(cfgCache), .cfgUser(cfgUser),
    .cfgOk(cfgOk), .lineAddr(cmdAddr), .lineBytes(cmdBytes),
    .cache(cmdCache), .user(cmdUser), .lastBeat(lastBeat), .lastLine(lastLine)
  );

  assign sTready = dataEn && wReady;
  assign wValid  = dataEn && sTvalid;
  assign wData   = sTdata;
  assign wLast   = dataEn && lastBeat;
endmodule

// File: rtl/rect_checker.sv
module rect_checker #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [ATTR_W-1:0] cmdCache,
  input logic [ATTR_W-1:0] cmdUser,
  input logic              sTvalid,
  input logic              sTready,
  input logic              sTlast,
  input logic              wValid,
  input logic              wReady,
  input logic              done,
  input logic              errCfg,
  input logic              errUnderrun,
  input logic              errOverrun
);
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdAddr) && $stable(cmdCache) && $stable(cmdUser));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !sTready && !wValid);

  assert_pass_beat_R3: assert property (@(posedge clk) disable iff (!rstN)
    sTvalid && sTready |-> wValid && wReady);

  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(sTvalid && sTready && sTlast));

  assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    errUnderrun |=> errUnderrun);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    errOverrun |=> errOverrun);

  assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (errUnderrun || errOverrun) |-> !sTready && !cmdValid);

  assert_cfg_refused_R8: assert property (@(posedge clk) disable iff (!rstN)
    errCfg |-> !cmdValid && !sTready && !done);
endmodule

bind rect_writer rect_checker #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdAddr(cmdAddr), .cmdCache(cmdCache), .cmdUser(cmdUser),
  .sTvalid(sTvalid), .sTready(sTready), .sTlast(sTlast),
  .wValid(wValid), .wReady(wReady), .done(done), .errCfg(errCfg),
  .errUnderrun(errUnderrun), .errOverrun(errOverrun)
);

// File: tb/rect_writer_tb.sv
module rect_writer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfgBase = '0;
  logic [15:0] cfgLineBytes = '0;
  logic [15:0] cfgStride = '0;
  logic [12:0] cfgLines = '0;
  logic [3:0]  cfgCache = '0;
  logic [3:0]  cfgUser = '0;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [31:0] cmdAddr;
  logic [15:0] cmdBytes;
  logic [3:0]  cmdCache;
  logic [3:0]  cmdUser;
  logic [31:0] sTdata = '0;
  logic        sTvalid = 1'b0;
  logic        sTlast = 1'b0;
  logic        sTready;
  logic [31:0] wData;
  logic        wValid;
  logic        wLast;
  logic        wReady = 1'b1;
  logic        done;
  logic        errCfg;
  logic        errUnderrun;
  logic        errOverrun;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  rect_writer dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgBase(cfgBase),
    .cfgLineBytes(cfgLineBytes), .cfgStride(cfgStride), .cfgLines(cfgLines),
    .cfgCache(cfgCache), .cfgUser(cfgUser), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdAddr(cmdAddr), .cmdBytes(cmdBytes),
    .cmdCache(cmdCache), .cmdUser(cmdUser), .sTdata(sTdata),
    .sTvalid(sTvalid), .sTlast(sTlast), .sTready(sTready), .wData(wData),
    .wValid(wValid), .wLast(wLast), .wReady(wReady), .done(done),
    .errCfg(errCfg), .errUnderrun(errUnderrun), .errOverrun(errOverrun)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; start = 1'b0; sTvalid = 1'b0; sTlast = 1'b0;
    cmdReady = 1'b0; wReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseStart(input logic [31:0] base, input logic [15:0] hb,
                            input logic [15:0] stride, input logic [12:0] lines,
                            input logic [3:0] cache, input logic [3:0] user);
    cfgBase = base; cfgLineBytes = hb; cfgStride = stride; cfgLines = lines;
    cfgCache = cache; cfgUser = user; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitCmd(input string req);
    int n = 0;
    while (!cmdValid && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk(req, "cmdValid", cmdValid, 1);
  endtask

  task automatic acceptCmd();
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
  endtask

  task automatic runXfer(input int run, input logic [15:0] hb, input logic [15:0] stride,
                         input int lines, input bit stall);
    logic [31:0] base;
    logic [3:0]  cache;
    logic [3:0]  user;
    int beats;
    base  = 32'h1000 + 32'(run) * 256;
    cache = 4'(run);
    user  = ~4'(run);
    beats = int'(hb) / 4;
    pulseStart(base, hb, stride, 13'(lines), cache, user);
    cfgBase = 32'hDEAD_0000; cfgStride = 16'h0FF0; cfgLines = 13'd7;
    cfgCache = ~cache; cfgUser = ~user; cfgLineBytes = 16'd400;
    for (int l = 0; l < lines; l++) begin
      waitCmd("R2");
      chk("R4", "sTready during cmd", sTready, 0);
      chk("R2", "cmdAddr", cmdAddr, base + 32'(l) * 32'(stride));
      chk("R1", "cmdBytes", cmdBytes, hb);
      chk("R10", "cmdCache", cmdCache, cache);
      chk("R10", "cmdUser", cmdUser, user);
      acceptCmd();
      for (int b = 0; b < beats; b++) begin
        sTvalid = 1'b1;
        sTdata  = 32'hA500_0000 | (32'(run) << 16) | (32'(l) << 8) | 32'(b);
        sTlast  = (l == lines - 1) && (b == beats - 1);
        if (stall && b == 0) begin
          wReady = 1'b0;
          #1;
          chk("R3", "sTready under stall", sTready, 0);
          @(negedge clk);
          wReady = 1'b1;
        end
        #1;
        chk("R3", "wValid", wValid, 1);
        chk("R3", "wData", wData, sTdata);
        chk("R3", "wLast", wLast, b == beats - 1);
        chk("R3", "sTready", sTready, 1);
        chk("R4", "no cmd during data", cmdValid, 0);
        @(negedge clk);
        sTvalid = 1'b0;
        sTlast  = 1'b0;
      end
    end
    chk("R5", "done", done, 1);
    chk("R2", "no extra cmd", cmdValid, 0);
    @(negedge clk);
    chk("R5", "done one cycle", done, 0);
    chk("R9", "sTready idle", sTready, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int run;
    doReset();
    chk("R9", "reset sTready", sTready, 0);
    chk("R9", "reset cmdValid", cmdValid, 0);
    chk("R5", "reset done", done, 0);
    chk("R6", "reset errUnderrun", errUnderrun, 0);
    chk("R7", "reset errOverrun", errOverrun, 0);

    run = 0;
    for (int h = 1; h <= 3; h++) begin
      for (int n = 1; n <= 3; n++) begin
        for (int s = 0; s < 3; s++) begin
          logic [15:0] hb;
          logic [15:0] st;
          hb = 16'(h * 4);
          st = (s == 0) ? hb : (s == 1) ? hb + 16'd4 : 16'd64;
          runXfer(run, hb, st, n, run[0]);
          run++;
        end
      end
    end

    // R8: each illegal configuration on its own
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: pulseStart(32'h2000, 16'd8, 16'd16, 13'd0, 4'd3, 4'd0);
        1: pulseStart(32'h2002, 16'd8, 16'd16, 13'd2, 4'd3, 4'd0);
        2: pulseStart(32'h2000, 16'd6, 16'd16, 13'd2, 4'd3, 4'd0);
        default: pulseStart(32'h2000, 16'd0, 16'd16, 13'd2, 4'd3, 4'd0);
      endcase
      chk("R8", "errCfg", errCfg, 1);
      chk("R8", "no cmd", cmdValid, 0);
      @(negedge clk);
      chk("R8", "errCfg pulse", errCfg, 0);
      chk("R8", "still idle", cmdValid, 0);
    end

    // R1: normal cache value after refusals
    runXfer(3, 16'd4, 16'd4, 1, 1'b0);

    // R6: TLAST at end of a non-final line
    pulseStart(32'h3000, 16'd8, 16'd32, 13'd2, 4'd3, 4'd0);
    waitCmd("R6");
    acceptCmd();
    sTvalid = 1'b1; sTlast = 1'b0; sTdata = 32'h1;
    @(negedge clk);
    sTlast = 1'b1; sTdata = 32'h2;
    @(negedge clk);
    chk("R6", "errUnderrun", errUnderrun, 1);
    chk("R6", "sTready halted", sTready, 0);
    chk("R6", "no cmd", cmdValid, 0);
    chk("R7", "errOverrun clear", errOverrun, 0);
    sTvalid = 1'b0; sTlast = 1'b0;
    pulseStart(32'h3000, 16'd8, 16'd32, 13'd2, 4'd3, 4'd0);
    @(negedge clk);
    chk("R6", "start ignored", cmdValid, 0);
    chk("R6", "still flagged", errUnderrun, 1);
    doReset();

    // R6: TLAST on first beat
    pulseStart(32'h3100, 16'd8, 16'd8, 13'd1, 4'd3, 4'd0);
    waitCmd("R6");
    acceptCmd();
    sTvalid = 1'b1; sTlast = 1'b1;
    @(negedge clk);
    sTvalid = 1'b0; sTlast = 1'b0;
    chk("R6", "early errUnderrun", errUnderrun, 1);
    chk("R5", "no done on underrun", done, 0);
    doReset();

    // R7: final beat without TLAST
    pulseStart(32'h3200, 16'd4, 16'd4, 13'd1, 4'd3, 4'd0);
    waitCmd("R7");
    acceptCmd();
    sTvalid = 1'b1; sTlast = 1'b0;
    @(negedge clk);
    sTvalid = 1'b0;
    chk("R7", "errOverrun", errOverrun, 1);
    chk("R7", "halt sTready", sTready, 0);
    chk("R5", "no done on overrun", done, 0);
    chk("R6", "errUnderrun clear", errUnderrun, 0);
    @(negedge clk);
    chk("R7", "overrun sticky", errOverrun, 1);
    doReset();
    chk("R7", "reset clears", errOverrun, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule